// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a 32-bit single-cycle processor and picks the address of the next instruction. On each enabled clock edge it loads one of four candidates: the following word, a PC-relative branch target, a jump target that stays inside the current 256 MB region, or an address taken from a register operand. The decoder supplies a 2-bit select and the ALU supplies a branch-condition flag. A branch is taken only when that flag is high. If the flag is low, the select falls back to the following word.

The block also drives the return address that linking jumps write into the register file. That value is the current PC plus eight. A synchronous reset loads the boot address and overrides every other input. When the clock enable is low, the PC holds its value.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_out` becomes 0xBFC00000 after that edge, whatever the values of `en`, `pc_sel`, `br_cond`, `instr` and `jreg_val`.
- R2: With `rst` low and `en` low at a rising edge, `pc_out` is unchanged after that edge for every select value.
- R3: Select code 0 (sequential) loads `pc_out + 4`, modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.
- R4: Select code 1 (branch) with `br_cond` high loads `pc_out + 4 + (sign-extended instr[15:0] << 2)`, modulo 2^32. Offsets from 0x8000 to 0xFFFF step backward.
- R5: Select code 1 with `br_cond` low loads `pc_out + 4`.
- R6: Select code 2 (region jump) loads `{ (pc_out+4)[31:28], instr[25:0], 2'b00 }`. The upper four bits come from the incremented PC, so a jump from the last word of a region lands in the next region.
- R7: Select code 3 (register jump) loads `jreg_val` unchanged.
- R8: `link_out` equals `pc_out + 8` modulo 2^32 at all times, combinationally.
- R9: `br_cond` has no effect when the select code is 0, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads the boot address |
| en | input | 1 | Clock enable; the PC updates only when high |
| pc_sel | input | 2 | Next-address select: 0 sequential, 1 branch, 2 region jump, 3 register jump |
| br_cond | input | 1 | Branch condition from the ALU |
| instr | input | 32 | Current instruction word; [15:0] branch offset, [25:0] jump index |
| jreg_val | input | 32 | Register operand for register jumps |
| pc_out | output | 32 | Current program counter |
| link_out | output | 32 | Return address, PC plus eight |

## Verification
Reset and a jump request can arrive on the same edge, and so can reset and a low clock enable. The bench drives each select code, and also a low enable, together with reset. In every case the PC must come back as the boot address. A branch select with the condition low is the other collision. The bench sweeps it against offsets that would move the PC forward or back, and accepts only PC plus four.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int XLEN      = 32;
  localparam int SEL_W     = 2;
  localparam int OFF_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int WORD_SH   = 2;
  localparam int REGION_W  = XLEN - JIDX_W - WORD_SH;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(1 << WORD_SH);
  localparam logic [XLEN-1:0] BOOT_DEFAULT = 32'hBFC0_0000;

  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic [SEL_W-1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_REGION = 2'd2,
    NXT_REG    = 2'd3
  } nxt_sel_e;

  typedef struct packed {
    addr_t seq;
    addr_t branch;
    addr_t region;
    addr_t regjmp;
  } cand_t;

  function automatic addr_t add_words(input addr_t base, input int unsigned nwords);
    return base + addr_t'(nwords) * WORD_BYTES;
  endfunction

  function automatic addr_t branch_target(input addr_t pc_next, input logic [OFF_W-1:0] off);
    addr_t ext;
    ext = {{(XLEN-OFF_W-WORD_SH){off[OFF_W-1]}}, off, {WORD_SH{1'b0}}};
    return pc_next + ext;
  endfunction

  function automatic addr_t region_target(input addr_t pc_next, input logic [JIDX_W-1:0] idx);
    return {pc_next[XLEN-1 -: REGION_W], idx, {WORD_SH{1'b0}}};
  endfunction

endpackage

// File: rtl/pcs_targets.sv
module pcs_targets
  import pcs_pkg::*;
(
  input  addr_t       pc,
  input  addr_t       instr,
  input  addr_t       jreg_val,
  output cand_t       cand,
  output addr_t       link
);

  addr_t pc_plus4;
  logic  unused_opbits;

  assign unused_opbits = ^instr[XLEN-1:JIDX_W];

  always_comb begin
    pc_plus4     = add_words(pc, 1);
    cand.seq     = pc_plus4;
    cand.branch  = branch_target(pc_plus4, instr[OFF_W-1:0]);
    cand.region  = region_target(pc_plus4, instr[JIDX_W-1:0]);
    cand.regjmp  = jreg_val;
    link         = add_words(pc, 2);
  end

endmodule

// File: rtl/pcs_select.sv
module pcs_select
  import pcs_pkg::*;
#(
  parameter bit GATE_BRANCH = 1'b1
)(
  input  logic [SEL_W-1:0] sel,
  input  logic             cond,
  input  cand_t            cand,
  output addr_t            next_pc,
  output logic             branch_go
);

  nxt_sel_e sel_e;
  assign sel_e = nxt_sel_e'(sel);

  generate
    if (GATE_BRANCH) begin : g_gated
      assign branch_go = (sel_e == NXT_BRANCH) && cond;
    end else begin : g_ungated
      logic unused_cond;
      assign unused_cond = cond;
      assign branch_go   = (sel_e == NXT_BRANCH);
    end
  endgenerate

  always_comb begin
    unique case (sel_e)
      NXT_SEQ:    next_pc = cand.seq;
      NXT_BRANCH: next_pc = branch_go ? cand.branch : cand.seq;
      NXT_REGION: next_pc = cand.region;
      NXT_REG:    next_pc = cand.regjmp;
      default:    next_pc = cand.seq;
    endcase
  end

endmodule

// File: rtl/pcs_pcreg.sv
module pcs_pcreg
  import pcs_pkg::*;
#(
  parameter addr_t BOOT_ADDR = BOOT_DEFAULT
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  addr_t d,
  output addr_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= BOOT_ADDR;
    else if (en) q <= d;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter logic [31:0] BOOT_ADDR   = 32'hBFC0_0000,
  parameter bit          GATE_BRANCH = 1'b1
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [1:0]  pc_sel,
  input  logic        br_cond,
  input  logic [31:0] instr,
  input  logic [31:0] jreg_val,
  output logic [31:0] pc_out,
  output logic [31:0] link_out
);

  addr_t pc_q;
  addr_t next_pc;
  cand_t cand;
  logic  branch_go;
  logic  load_pc;

  assign load_pc = en && !rst;

  pcs_targets u_targets (
    .pc       (pc_q),
    .instr    (instr),
    .jreg_val (jreg_val),
    .cand     (cand),
    .link     (link_out)
  );

  pcs_select #(.GATE_BRANCH(GATE_BRANCH)) u_select (
    .sel       (pc_sel),
    .cond      (br_cond),
    .cand      (cand),
    .next_pc   (next_pc),
    .branch_go (branch_go)
  );

  pcs_pcreg #(.BOOT_ADDR(BOOT_ADDR)) u_pcreg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_pc),
    .q   (pc_q)
  );

  assign pc_out = pc_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter logic [31:0] BOOT_ADDR = 32'hBFC0_0000
)(
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [1:0]  pc_sel,
  input logic        br_cond,
  input logic [31:0] instr,
  input logic [31:0] jreg_val,
  input logic [31:0] pc_out,
  input logic [31:0] link_out,
  input logic [31:0] next_pc,
  input logic        branch_go,
  input logic        load_pc
);

  logic [31:0] inc4;
  logic [31:0] br_dest;

  assign inc4    = pc_out + 32'd4;
  assign br_dest = inc4 + {{14{instr[15]}}, instr[15:0], 2'b00};

  // R1
  boot_load_chk: assert property (@(posedge clk) $fell(rst) |-> pc_out == BOOT_ADDR);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_out));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pc_sel == 2'd0) |=> pc_out == $past(inc4));

  // R4
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pc_sel == 2'd1 && br_cond) |=> pc_out == $past(br_dest));

  // R5
  branch_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pc_sel == 2'd1 && !br_cond) |=> pc_out == $past(inc4));

  // R6
  region_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pc_sel == 2'd2) |=> (pc_out[27:0] == {$past(instr[25:0]), 2'b00}
                               && pc_out[31:28] == $past(inc4[31:28])));

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pc_sel == 2'd3) |=> pc_out == $past(jreg_val));

  // R9
  cond_only_branch_chk: assert property (@(posedge clk) disable iff (rst)
    branch_go |-> (pc_sel == 2'd1 && br_cond));

  // R8
  link_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (link_out - pc_out) == 32'd8);

  // R2
  load_gate_chk: assert property (@(posedge clk) disable iff (rst)
    load_pc |=> pc_out == $past(next_pc));

endmodule

bind pc_sequencer pc_sequencer_chk #(.BOOT_ADDR(BOOT_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .pc_sel    (pc_sel),
  .br_cond   (br_cond),
  .instr     (instr),
  .jreg_val  (jreg_val),
  .pc_out    (pc_out),
  .link_out  (link_out),
  .next_pc   (next_pc),
  .branch_go (branch_go),
  .load_pc   (load_pc)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  pc_sel = 2'd0;
  logic        br_cond = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [31:0] jreg_val = 32'd0;
  logic [31:0] pc_out;
  logic [31:0] link_out;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model_pc;

  always #10 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .en(en), .pc_sel(pc_sel), .br_cond(br_cond),
    .instr(instr), .jreg_val(jreg_val), .pc_out(pc_out), .link_out(link_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    compared++;
    if (got !== want) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  function automatic logic [31:0] predict(input logic [31:0] pc, input logic e, input logic [1:0] s,
                                          input logic c, input logic [31:0] iw, input logic [31:0] rj);
    longint off;
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (!e) return pc;
    case (s)
      2'd0: return p4;
      2'd1: begin
        off = iw[15] ? longint'(iw[15:0]) - 65536 : longint'(iw[15:0]);
        return c ? 32'(longint'(p4) + off * 4) : p4;
      end
      2'd2: return (p4 & 32'hF000_0000) | ((iw & 32'h03FF_FFFF) * 4);
      default: return rj;
    endcase
  endfunction

  function automatic string req_of(input logic e, input logic [1:0] s, input logic c);
    if (!e) return "R2";
    case (s)
      2'd0: return c ? "R9" : "R3";
      2'd1: return c ? "R4" : "R5";
      2'd2: return c ? "R9" : "R6";
      default: return c ? "R9" : "R7";
    endcase
  endfunction

  task automatic step(input logic r, input logic e, input logic [1:0] s, input logic c,
                      input logic [31:0] iw, input logic [31:0] rj, input string req);
    @(negedge clk);
    rst = r; en = e; pc_sel = s; br_cond = c; instr = iw; jreg_val = rj;
    #1;
    check("R8", link_out, model_pc + 32'd8);
    model_pc = r ? BOOT : predict(model_pc, e, s, c, iw, rj);
    @(posedge clk);
    #2;
    check(req, pc_out, model_pc);
  endtask

  initial begin
    logic [31:0] starts [5];
    logic [31:0] words  [5];
    starts = '{32'h0040_0000, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 32'h0FFF_FFFC, BOOT};
    words  = '{32'h0000_0000, 32'h03FF_FFFF, 32'h0123_8000, 32'h1000_7FFF, 32'hFC00_FFFF};

    // reset state (R1)
    repeat (2) @(posedge clk);
    #2;
    check("R1", pc_out, BOOT);
    model_pc = BOOT;
    check("R8", link_out, BOOT + 32'd8);

    // main sweep: every start, select, condition, enable and instruction pattern
    for (int si = 0; si < 5; si++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 2; e++)
            for (int wi = 0; wi < 5; wi++) begin
              step(1'b0, 1'b1, 2'd3, 1'b0, 32'd0, starts[si], "R7");
              step(1'b0, e[0], s[1:0], c[0], words[wi], ~starts[si],
                   req_of(e[0], s[1:0], c[0]));
            end

    // reset colliding with every select and with enable low (R1)
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++) begin
        step(1'b0, 1'b1, 2'd3, 1'b0, 32'd0, 32'h1234_5678, "R7");
        step(1'b1, e[0], s[1:0], 1'b1, 32'hFFFF_FFFF, 32'h0000_0100, "R1");
      end

    // wrap of sequential increment at top of space (R3)
    step(1'b0, 1'b1, 2'd3, 1'b0, 32'd0, 32'hFFFF_FFFC, "R7");
    step(1'b0, 1'b1, 2'd0, 1'b0, 32'd0, 32'd0, "R3");
    check("R3", pc_out, 32'h0000_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule